// File: doc/BRIEF.md
# Data Watchpoint Address Match Unit

This block holds a bank of data watchpoint slots and compares every load or store that the core issues against all of them in parallel. Each slot has a 64-bit base value and a control word. Both are written through a single register-write port that carries a slot index and a select between the two words. For each access the block receives the virtual address, the access size, the direction (load or store) and the privilege level. One cycle later it reports whether any slot matched and which slot that was.

A slot works in one of two ways. In byte mode it covers any chosen set of bytes inside one aligned 8-byte doubleword. In region mode it covers a naturally aligned power-of-two region. A slot can be restricted to loads, to stores or to both, and it can be restricted to user level, to kernel level or to both. An access hits a slot when any byte the access touches lies inside the slot's coverage, and this includes accesses that straddle two doublewords.

Top module: `dw_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `hit` is 0 and `hit_idx` is 0. Reset clears every slot's control word and base value to zero.
- R2: Control bit 0 enables the slot. A slot with bit 0 clear never reports a hit.
- R3: Control bit 1 allows hits from kernel accesses (`acc_priv`=1). Control bit 2 allows hits from user accesses (`acc_priv`=0). The value 3 in bits [2:1] allows both levels.
- R4: Control bits [4:3] filter by direction. 01 matches loads only (`acc_store`=0), 10 matches stores only (`acc_store`=1), and 11 matches both.
- R5: When the mask width is zero, control bits [12:5] select bytes. Bit 5+k covers byte k of the doubleword at the base value with its low three bits ignored. An access hits when one of its bytes is a selected byte.
- R6: An access of 2^`acc_size` bytes (`acc_size` 0..3) that crosses a doubleword boundary is compared against both doublewords it touches.
- R7: Control bits [28:24] hold a mask width M. When M is 3 or more, the slot covers the aligned 2^M-byte region that contains the base value. Such a slot only hits when bits [12:5] are all ones.
- R8: A slot whose M is 1 or 2, or whose bits [4:3] are 00, never reports a hit.
- R9: When several slots match, `hit_idx` gives the lowest-numbered one. When there is no hit, `hit_idx` is 0.
- R10: `hit` and `hit_idx` are registered and reflect the access presented in the previous cycle. When `acc_valid` is low, `hit` is 0 on the next cycle.
- R11: A write with `cfg_sel`=0 loads the control word from `cfg_wdata[31:0]`. A write with `cfg_sel`=1 loads the base value from `cfg_wdata`. The new contents apply to accesses from the next cycle on. A write to an index of `NSLOT` or above changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Slot register write strobe |
| cfg_sel | input | 1 | 0 writes the control word, 1 writes the base value |
| cfg_idx | input | IW | Slot index for the write |
| cfg_wdata | input | 64 | Write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 64 | Virtual address of the first byte |
| acc_size | input | 2 | log2 of the access size in bytes |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_priv | input | 1 | 1 for kernel level, 0 for user level |
| hit | output | 1 | Registered match flag |
| hit_idx | output | IW | Registered index of the lowest matching slot |

## Verification
A corrupted slot word shows up on the first access that targets the affected bytes. The symptom is a missing hit, a spurious hit, or a wrong index one cycle after that access. An error in lane decoding or in the mask only shows at the edges of the covered range. For that reason the directed cases probe the first and last covered byte, the neighbouring bytes, and accesses that straddle a doubleword boundary. A priority error only appears when two enabled slots overlap, so that case is set up on purpose. The reference model is compared with the design on every cycle, so any divergence is reported in the cycle in which it occurs.

// File: rtl/dw_pkg.sv
// Shared types for the data watchpoint unit.
// Assumes: only the decoded control fields are kept; the other bits are dropped on write.
package dw_pkg;
    typedef struct packed {
        logic       en;     // slot enable
        logic [1:0] priv;   // [0] kernel allowed, [1] user allowed
        logic [1:0] ls;     // [0] loads, [1] stores
        logic [7:0] bsel;   // byte lanes of the doubleword
        logic [4:0] mw;     // mask width, 0 = byte mode
    } slot_cfg_t;

    // Extract the stored fields from a 32-bit control write.
    function automatic slot_cfg_t cfg_from_word(input logic [31:0] w);
        slot_cfg_t c;
        c.en   = w[0];
        c.priv = w[2:1];
        c.ls   = w[4:3];
        c.bsel = w[12:5];
        c.mw   = w[28:24];
        return c;
    endfunction
endpackage

// File: rtl/dw_slot.sv
// Match logic for a single watchpoint slot (purely combinational).
// Assumes: an access is at most 8 bytes long, so it touches at most two doublewords,
// and a region-mode slot is at least 8 bytes wide, so checking the two end bytes is enough.
module dw_slot
    import dw_pkg::*;
(
    input  slot_cfg_t   cfg,
    input  logic [60:0] base_dw,
    input  logic [63:0] acc_addr,
    input  logic [1:0]  acc_size,
    input  logic        acc_store,
    input  logic        acc_priv,
    output logic        match
);
    logic [63:0] last_addr;
    logic        same_dw;
    logic [2:0]  first_hi;
    logic [7:0]  lanes_first;
    logic [7:0]  lanes_last;
    logic        byte_hit;
    logic [63:0] region_mask;
    logic [63:0] base_full;
    logic        region_hit;
    logic        filt_ok;

    // Address of the last byte the access touches.
    always_comb last_addr = acc_addr + ((64'd1 << acc_size) - 64'd1);

    // Lanes touched in the first doubleword, and in the second one if the access crosses.
    always_comb begin
        same_dw     = (acc_addr[63:3] == last_addr[63:3]);
        first_hi    = same_dw ? last_addr[2:0] : 3'd7;
        lanes_first = (8'hFF << acc_addr[2:0]) & (8'hFF >> (3'd7 - first_hi));
        lanes_last  = 8'hFF >> (3'd7 - last_addr[2:0]);
    end

    // Byte mode: overlap with the selected lanes of the base doubleword.
    always_comb byte_hit =
        ((acc_addr[63:3] == base_dw) && |(lanes_first & cfg.bsel)) ||
        (!same_dw && (last_addr[63:3] == base_dw) && |(lanes_last & cfg.bsel));

    // Region mode: either end byte inside the aligned 2^M block.
    always_comb begin
        region_mask = ~((64'd1 << cfg.mw) - 64'd1);
        base_full   = {base_dw, 3'b000};
        region_hit  = (cfg.bsel == 8'hFF) &&
                      ((((acc_addr  ^ base_full) & region_mask) == 64'd0) ||
                       (((last_addr ^ base_full) & region_mask) == 64'd0));
    end

    // Enable, direction, privilege and reserved-width qualification.
    always_comb filt_ok = cfg.en &&
                          (acc_store ? cfg.ls[1] : cfg.ls[0]) &&
                          (acc_priv  ? cfg.priv[0] : cfg.priv[1]) &&
                          (cfg.mw != 5'd1) && (cfg.mw != 5'd2);

    // Final per-slot result.
    always_comb match = filt_ok && ((cfg.mw == 5'd0) ? byte_hit : region_hit);
endmodule

// File: rtl/dw_prio.sv
// Lowest-index-wins priority encoder over the per-slot match vector.
// Assumes: IW is wide enough to hold NSLOT-1.
module dw_prio #(
    parameter int NSLOT = 4,
    parameter int IW    = 2
) (
    input  logic [NSLOT-1:0] req,
    output logic             any,
    output logic [IW-1:0]    idx
);
    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dw_unit.sv
// Top of the data watchpoint unit: slot register bank, parallel match, priority and
// the registered result.
// Assumes: NSLOT from 1 to 16; writes apply on the clock edge, so an access in the
// same cycle still sees the old contents.
module dw_unit
    import dw_pkg::*;
#(
    parameter int NSLOT = 4,
    localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [IW-1:0] cfg_idx,
    input  logic [63:0]   cfg_wdata,
    input  logic          acc_valid,
    input  logic [63:0]   acc_addr,
    input  logic [1:0]    acc_size,
    input  logic          acc_store,
    input  logic          acc_priv,
    output logic          hit,
    output logic [IW-1:0] hit_idx
);
    slot_cfg_t         cfg_q  [NSLOT];
    logic [60:0]       base_q [NSLOT];
    logic [NSLOT-1:0]  slot_match;
    logic [NSLOT-1:0]  slot_en;
    logic              any_match;
    logic [IW-1:0]     first_idx;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // Slot storage: written when the index matches, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[s]  <= '0;
                base_q[s] <= '0;
            end else if (cfg_we && (int'(cfg_idx) == s)) begin
                if (cfg_sel) base_q[s] <= cfg_wdata[63:3];
                else         cfg_q[s]  <= cfg_from_word(cfg_wdata[31:0]);
            end
        end

        // Enable bit brought out for the bound checker.
        always_comb slot_en[s] = cfg_q[s].en;

        dw_slot u_slot (
            .cfg       (cfg_q[s]),
            .base_dw   (base_q[s]),
            .acc_addr  (acc_addr),
            .acc_size  (acc_size),
            .acc_store (acc_store),
            .acc_priv  (acc_priv),
            .match     (slot_match[s])
        );
    end

    dw_prio #(.NSLOT(NSLOT), .IW(IW)) u_prio (
        .req (slot_match),
        .any (any_match),
        .idx (first_idx)
    );

    // Result register: one cycle after the access, and zero index on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            hit_idx <= '0;
        end else begin
            hit     <= acc_valid && any_match;
            hit_idx <= (acc_valid && any_match) ? first_idx : '0;
        end
    end
endmodule

// File: rtl/dw_unit_chk.sv
// Assertion checker for dw_unit, attached to every instance by bind.
// Assumes: slot_en is the enable bit of each slot as held in the register bank.
module dw_unit_chk #(
    parameter int NSLOT = 4,
    parameter int IW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             hit,
    input logic [IW-1:0]    hit_idx,
    input logic [NSLOT-1:0] slot_en
);
    logic [NSLOT-1:0] en_d;

    // Enable vector as it stood when the reported access was presented.
    always_ff @(posedge clk) en_d <= slot_en;

    AST_IDLE_NO_HIT:  assert property (@(posedge clk) disable iff (!rst_n)
                          !acc_valid |=> !hit);                          // R10
    AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                          !hit |-> (hit_idx == '0));                     // R9
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                          hit |-> (int'(hit_idx) < NSLOT));               // R11
    AST_HIT_ENABLED:  assert property (@(posedge clk) disable iff (!rst_n)
                          (hit && $past(rst_n)) |-> en_d[hit_idx]);       // R2
endmodule

bind dw_unit dw_unit_chk #(.NSLOT(NSLOT), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .slot_en   (slot_en)
);

// File: tb/sim_dw_unit.sv
`timescale 1ns/1ps
// Bench for dw_unit: byte-level reference model checked on every clock.
module sim_dw_unit;
    localparam int N  = 3;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [63:0]   cfg_wdata = '0;
    logic          acc_valid = 1'b0;
    logic [63:0]   acc_addr = '0;
    logic [1:0]    acc_size = '0;
    logic          acc_store = 1'b0, acc_priv = 1'b0;
    logic          hit;
    logic [IW-1:0] hit_idx;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_ctrl [N];
    logic [63:0] m_val  [N];

    always #2.5 clk = ~clk;

    dw_unit #(.NSLOT(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_store(acc_store),
        .acc_priv(acc_priv), .hit(hit), .hit_idx(hit_idx)
    );

    function automatic logic [63:0] mk(input bit en, input int pv, input int ls,
                                       input int bs, input int mw);
        return 64'((mw << 24) | (bs << 5) | (ls << 3) | (pv << 1) | int'(en));
    endfunction

    // Behavioural model: walk every byte of the access against every slot.
    function automatic int ref_hit(input logic [63:0] a, input int sz,
                                   input bit st, input bit pr);
        for (int s = 0; s < N; s++) begin
            logic [31:0] c = m_ctrl[s];
            int mw = int'(c[28:24]);
            bit ok = c[0] && (st ? c[4] : c[3]) && (pr ? c[1] : c[2])
                     && mw != 1 && mw != 2;
            if (!ok) continue;
            for (int i = 0; i < (1 << sz); i++) begin
                logic [63:0] b = a + 64'(i);
                if (mw == 0) begin
                    if (b[63:3] == m_val[s][63:3] && c[5 + int'(b[2:0])]) return s;
                end else begin
                    if (c[12:5] == 8'hFF && ((b ^ m_val[s]) >> mw) == 64'd0) return s;
                end
            end
        end
        return -1;
    endfunction

    task automatic check(input bit eh, input int ei, input string tag);
        checks++;
        if (hit !== eh || int'(hit_idx) !== ei) begin
            errors++;
            $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d",
                     tag, hit, hit_idx, eh, ei);
        end
    endtask

    // One clock: optional write plus optional access, checked right after the edge.
    task automatic step(input bit we, input bit sel, input int idx, input logic [63:0] wd,
                        input bit v, input logic [63:0] a, input int sz,
                        input bit st, input bit pr, input string tag);
        int e;
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_idx = IW'(idx); cfg_wdata = wd;
        acc_valid = v; acc_addr = a; acc_size = 2'(sz); acc_store = st; acc_priv = pr;
        e = v ? ref_hit(a, sz, st, pr) : -1;
        @(posedge clk);
        if (we && idx < N) begin
            if (sel) m_val[idx] = wd;
            else     m_ctrl[idx] = {3'b0, wd[28:24], 11'b0, wd[12:0]};
        end
        #1;
        check(e >= 0, (e >= 0) ? e : 0, tag);
    endtask

    task automatic wr(input int idx, input bit sel, input logic [63:0] wd, input string tag);
        step(1, sel, idx, wd, 0, 64'd0, 0, 0, 0, tag);
    endtask

    task automatic acc(input logic [63:0] a, input int sz, input bit st, input bit pr,
                       input string tag);
        step(0, 0, 0, 64'd0, 1, a, sz, st, pr, tag);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int s = 0; s < N; s++) begin m_ctrl[s] = '0; m_val[s] = '0; end
        repeat (3) @(posedge clk);
        #1 check(0, 0, "R1 during reset");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 check(0, 0, "R1 first cycle after reset");
        acc(64'd0, 3, 0, 1, "R1 cleared slots do not hit");

        // R5 byte mode, base low bits ignored
        wr(0, 1, 64'h1000_0005, "R11 base write");
        wr(0, 0, mk(1, 3, 3, 8'h0F, 0), "R11 ctrl write");
        acc(64'h1000_0002, 0, 0, 1, "R5 selected lane hit");
        acc(64'h1000_0004, 0, 0, 1, "R5 unselected lane miss");
        acc(64'h1000_0003, 1, 1, 0, "R5 partial overlap hit");
        // R4 direction filter
        wr(0, 0, mk(1, 3, 1, 8'h0F, 0), "R4 load only");
        acc(64'h1000_0000, 0, 1, 1, "R4 store rejected");
        acc(64'h1000_0000, 0, 0, 1, "R4 load accepted");
        wr(0, 0, mk(1, 3, 2, 8'h0F, 0), "R4 store only");
        acc(64'h1000_0000, 0, 0, 1, "R4 load rejected");
        acc(64'h1000_0000, 0, 1, 1, "R4 store accepted");
        // R3 privilege filter
        wr(0, 0, mk(1, 2, 3, 8'h0F, 0), "R3 user only");
        acc(64'h1000_0001, 0, 0, 1, "R3 kernel rejected");
        acc(64'h1000_0001, 0, 0, 0, "R3 user accepted");
        wr(0, 0, mk(1, 1, 3, 8'h0F, 0), "R3 kernel only");
        acc(64'h1000_0001, 0, 0, 0, "R3 user rejected");
        // R2 enable
        wr(0, 0, mk(0, 3, 3, 8'h0F, 0), "R2 disable");
        acc(64'h1000_0001, 0, 0, 1, "R2 disabled slot silent");
        // R11 write and access in the same cycle: old contents apply
        step(1, 0, 0, mk(1, 3, 3, 8'h0F, 0), 1, 64'h1000_0001, 0, 0, 1, "R11 same cycle old");
        acc(64'h1000_0001, 0, 0, 1, "R11 next cycle new");
        wr(3, 0, mk(1, 3, 3, 8'hFF, 0), "R11 out of range write");
        acc(64'h0, 3, 0, 1, "R11 out of range write ignored");
        wr(0, 0, 64'd0, "clear slot 0");
        // R6 crossing access
        wr(1, 1, 64'h2008, "R6 base");
        wr(1, 0, mk(1, 3, 3, 8'h01, 0), "R6 ctrl");
        acc(64'h2006, 2, 0, 1, "R6 crossing hits second doubleword");
        acc(64'h2004, 2, 0, 1, "R6 stops short of base");
        wr(1, 0, mk(1, 3, 3, 8'h80, 0), "R6 top lane");
        wr(1, 1, 64'h2000, "R6 base low");
        acc(64'h2006, 2, 1, 1, "R6 crossing hits first doubleword");
        // R7 region mode
        wr(2, 1, 64'h5000_0ABC, "R7 base");
        wr(2, 0, mk(1, 3, 3, 8'hFF, 12), "R7 ctrl");
        acc(64'h5000_0FFC, 3, 0, 1, "R7 tail of region");
        acc(64'h5000_1000, 0, 0, 1, "R7 past region");
        acc(64'h4FFF_FFFC, 3, 0, 1, "R7 head of region");
        acc(64'h4FFF_FFF8, 2, 0, 1, "R7 before region");
        wr(2, 0, mk(1, 3, 3, 8'h7F, 12), "R7 partial byte select");
        acc(64'h5000_0100, 0, 0, 1, "R7 region requires full byte select");
        // R8 reserved widths and empty direction field
        wr(2, 0, mk(1, 3, 3, 8'hFF, 2), "R8 width 2");
        acc(64'h5000_0AB8, 0, 0, 1, "R8 width 2 silent");
        wr(2, 0, mk(1, 3, 3, 8'hFF, 1), "R8 width 1");
        acc(64'h5000_0AB8, 0, 0, 1, "R8 width 1 silent");
        wr(2, 0, mk(1, 3, 0, 8'hFF, 12), "R8 ls 00");
        acc(64'h5000_0AB8, 0, 0, 1, "R8 ls 00 silent");
        // R9 priority
        wr(1, 1, 64'h3008, "R9 base 1");
        wr(1, 0, mk(1, 3, 3, 8'h01, 0), "R9 ctrl 1");
        wr(2, 1, 64'h3000, "R9 base 2");
        wr(2, 0, mk(1, 3, 3, 8'hFF, 12), "R9 ctrl 2");
        acc(64'h3008, 0, 0, 1, "R9 lowest of two wins");
        wr(0, 1, 64'h3008, "R9 base 0");
        wr(0, 0, mk(1, 3, 3, 8'h01, 0), "R9 ctrl 0");
        acc(64'h3008, 0, 0, 1, "R9 slot 0 wins");
        acc(64'h3009, 0, 0, 1, "R9 only region slot");
        // R10 valid low
        step(0, 0, 0, 64'd0, 0, 64'h3008, 0, 0, 1, "R10 idle no hit");
        // Mixed stimulus around a small window, model checked every cycle
        for (int k = 0; k < 2000; k++) begin
            int r = int'($urandom % 8);
            if (r == 0)
                wr(int'($urandom % 4), 1, 64'h3000 + 64'($urandom % 64), "R5 R7 mixed base");
            else if (r == 1)
                wr(int'($urandom % 4), 0,
                   mk(1'($urandom), int'($urandom % 4), int'($urandom % 4),
                      ($urandom % 2) ? 8'hFF : int'($urandom % 256), int'($urandom % 7)),
                   "R2 R3 R4 R8 mixed ctrl");
            else
                step(0, 0, 0, 64'd0, 1'($urandom % 8 != 0), 64'h2FF8 + 64'($urandom % 96),
                     int'($urandom % 4), 1'($urandom), 1'($urandom), "R6 R9 R10 mixed access");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule